// File: doc/BRIEF.md
# Stereo Audio Sample FIFO

This block buffers compressed voice data between a host bus and an audio codec datapath. In the two playback modes the host or a DMA engine fills the buffer, and the codec drains it one byte at a time. In record mode the codec fills it and the host drains it. Mono playback and record use the left channel only. Stereo playback keeps separate left and right buffers. Each buffer can be limited to 256, 512 or 1024 bits. A 16-bit host write stores two bytes, and an 8-bit write stores one.

Each channel produces registered empty, half-full and full flags. A channel-select input chooses which channel's flags drive the shared status pins. Playback on a channel may start only once its half-full flag has been seen. Each channel has its own DMA request and acknowledge. A configuration vector inverts the active level of each status and handshake line.

Top module: `stereo_audio_fifo`

## Requirements
- R1: The capacity select sets the per-channel capacity: `0` gives 32 bytes (256 bits), `1` gives 64 bytes (512 bits), and `2` or `3` gives 128 bytes (1024 bits). The full flag asserts exactly when that many bytes are held.
- R2: The empty flag is true exactly when a channel holds zero bytes. All flags are registered and reflect the operations accepted at the most recent clock edge. A codec or host read of an empty channel is refused.
- R3: The half-full flag is true when the count is strictly greater than half the capacity. For a 32-byte capacity it is false at 16 bytes and true at 17.
- R4: A write is refused when the full flag is set. A 16-bit write is also refused when fewer than two bytes are free.
- R5: With `wide`=1, a write stores `host_wdata[7:0]` first and `[15:8]` second. With `wide`=0, only `[7:0]` is stored. Bytes are read out in write order, and each byte appears on the read data output in the clock after its read is accepted.
- R6: In a playback mode, a channel's `synth_go` output rises one clock after that channel's half-full flag is first set. It stays high for as long as the mode remains a playback mode. Codec reads of a channel are accepted only while its `synth_go` is high.
- R7: Mode encoding is 0 = mono playback, 1 = stereo playback, 2 = record, 3 = idle. In stereo playback, `host_ch`=0 writes the left channel and 1 writes the right. The status pins show the right channel when `ch_sel`=1 and the left channel when it is 0. In every other mode the status pins show the left channel and `ch_sel` has no effect.
- R8: With `dma_en`=1, the left request is raw-active in playback modes while left is not full, and in record mode while left is not empty. The right request is raw-active only in stereo playback while right is not full. With `dma_en`=0 both requests are raw-inactive.
- R9: A `dma_wr` strobe writes the left channel only while the left acknowledge is active. It writes the right channel only while the right acknowledge is active and the left acknowledge is not. With neither acknowledge active, it changes nothing.
- R10: `pol` bits invert active levels. Bit 0 inverts empty, bit 1 inverts half-full, bit 2 inverts full and bit 3 inverts both requests. With bit 4 clear the acknowledges are active low; with bit 4 set they are active high.
- R11: In 8-bit width, a write and a read accepted on the same channel in the same clock leave its count unchanged.
- R12: In record mode, `codec_wr` stores `codec_wdata` into the left channel. A `host_rd`, or a `dma_rd` with the left acknowledge active, removes one byte, which appears on `host_rdata` in the next clock.
- R13: Idle mode empties both channels within one clock and clears both `synth_go` outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 mono play, 1 stereo play, 2 record, 3 idle |
| size_sel | input | 2 | Capacity select |
| wide | input | 1 | 1: host/DMA writes carry 16 bits, 0: 8 bits |
| dma_en | input | 1 | Enables the DMA handshakes |
| pol | input | 5 | Polarity controls (see R10) |
| ch_sel | input | 1 | Status channel select in stereo |
| host_ch | input | 1 | Host write channel in stereo |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host/DMA write data |
| host_rd | input | 1 | Host read strobe (record) |
| host_rdata | output | 8 | Byte read by host or DMA |
| dma_wr | input | 1 | DMA write strobe |
| dma_rd | input | 1 | DMA read strobe (record) |
| dack_l | input | 1 | Left DMA acknowledge |
| dack_r | input | 1 | Right DMA acknowledge |
| dreq_l | output | 1 | Left DMA request |
| dreq_r | output | 1 | Right DMA request |
| codec_rd_l | input | 1 | Codec read strobe, left |
| codec_rd_r | input | 1 | Codec read strobe, right |
| codec_rdata_l | output | 8 | Byte to codec, left |
| codec_rdata_r | output | 8 | Byte to codec, right |
| codec_wr | input | 1 | Codec write strobe (record) |
| codec_wdata | input | 8 | Codec write byte |
| flag_empty | output | 1 | Selected channel empty flag |
| flag_half | output | 1 | Selected channel half-full flag |
| flag_full | output | 1 | Selected channel full flag |
| synth_go_l | output | 1 | Left playback may run |
| synth_go_r | output | 1 | Right playback may run |

## Verification
A table-driven run on a 32-byte mono buffer steps the count across 16/17 bytes, up to full, past full with extra writes, through paired write and read, and down past empty. This separates off-by-one errors in the flag thresholds from errors in refusal and count updates. Patterned 16-bit words read back byte by byte expose byte-order and bank-interleave faults. A write of 16 bits with only one byte free tells a room check apart from a full-flag-only check. Stereo, DMA, polarity and record scenarios each drive one channel and watch the other. Misrouted writes, selection faults and handshake faults therefore appear as a flag on the wrong side.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  typedef enum logic [1:0] {
    MODE_MONO   = 2'd0,
    MODE_STEREO = 2'd1,
    MODE_REC    = 2'd2,
    MODE_IDLE   = 2'd3
  } afifo_mode_e;

  localparam int POL_EMPTY = 0;
  localparam int POL_HALF  = 1;
  localparam int POL_FULL  = 2;
  localparam int POL_REQ   = 3;
  localparam int POL_ACK   = 4;
  localparam int POL_W     = 5;
endpackage

// File: rtl/afifo_bank.sv
module afifo_bank #(
  parameter int DEPTH = 64,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic          re,
  input  logic [IW-1:0] ra,
  output logic [7:0]    rq
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/afifo_chan.sv
module afifo_chan #(
  parameter int MAX_BYTES = 128,
  parameter int AW        = 7,
  parameter int CW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] cap,
  input  logic          wr_en,
  input  logic          wr_two,
  input  logic [15:0]   wr_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          empty,
  output logic          half,
  output logic          full
);
  localparam int DEPTH = MAX_BYTES / 2;
  localparam int IW    = AW - 1;

  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count, cnt_nxt, nb;
  logic          wr_ok, rd_ok, rsel_q;
  logic [1:0]    bwe, bre;
  logic [IW-1:0] bwa [2];
  logic [7:0]    bwd [2];
  logic [7:0]    brq [2];

  assign nb    = wr_two ? CW'(2) : CW'(1);
  assign wr_ok = wr_en && !clr && ((count + nb) <= cap);
  assign rd_ok = rd_en && !clr && (count != '0);

  always_comb begin
    if (clr) cnt_nxt = '0;
    else     cnt_nxt = count + (wr_ok ? nb : '0) - (rd_ok ? CW'(1) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; count <= '0; rsel_q <= 1'b0;
      empty <= 1'b1; half <= 1'b0; full <= 1'b0;
    end else begin
      count <= cnt_nxt;
      empty <= (cnt_nxt == '0);
      half  <= (cnt_nxt > (cap >> 1));
      full  <= (cnt_nxt >= cap);
      if (clr) begin
        wp <= '0; rp <= '0;
      end else begin
        if (wr_ok) wp <= wp + AW'(nb);
        if (rd_ok) begin
          rp     <= rp + AW'(1);
          rsel_q <= rp[0];
        end
      end
    end
  end

  // two byte-wide banks interleaved on the pointer LSB
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic          lead;
    logic [AW-1:0] waddr;
    assign lead     = (wp[0] == 1'(b));
    assign waddr    = lead ? wp : wp + AW'(1);
    assign bwe[b]   = wr_ok && (lead || wr_two);
    assign bwa[b]   = waddr[AW-1:1];
    assign bwd[b]   = lead ? wr_data[7:0] : wr_data[15:8];
    assign bre[b]   = rd_ok && (rp[0] == 1'(b));

    afifo_bank #(.DEPTH(DEPTH), .IW(IW)) u_bank (
      .clk (clk),
      .we  (bwe[b]),
      .wa  (bwa[b]),
      .wd  (bwd[b]),
      .re  (bre[b]),
      .ra  (rp[AW-1:1]),
      .rq  (brq[b])
    );
  end

  assign rd_data = rsel_q ? brq[1] : brq[0];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en && !clr && $stable(cap)) |=> $stable(count)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !wr_en && !clr) |=> $stable(count)); // R2
  AST_SAME_COUNT: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && rd_ok && !wr_two) |=> $stable(count)); // R11
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(MAX_BYTES)); // R1
endmodule

// File: rtl/stereo_audio_fifo.sv
module stereo_audio_fifo
  import afifo_pkg::*;
#(
  parameter int MAX_BITS = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [1:0]       size_sel,
  input  logic             wide,
  input  logic             dma_en,
  input  logic [POL_W-1:0] pol,
  input  logic             ch_sel,
  input  logic             host_ch,
  input  logic             host_wr,
  input  logic [15:0]      host_wdata,
  input  logic             host_rd,
  output logic [7:0]       host_rdata,
  input  logic             dma_wr,
  input  logic             dma_rd,
  input  logic             dack_l,
  input  logic             dack_r,
  output logic             dreq_l,
  output logic             dreq_r,
  input  logic             codec_rd_l,
  input  logic             codec_rd_r,
  output logic [7:0]       codec_rdata_l,
  output logic [7:0]       codec_rdata_r,
  input  logic             codec_wr,
  input  logic [7:0]       codec_wdata,
  output logic             flag_empty,
  output logic             flag_half,
  output logic             flag_full,
  output logic             synth_go_l,
  output logic             synth_go_r
);
  localparam int MAX_BYTES = MAX_BITS / 8;
  localparam int MIN_BYTES = MAX_BYTES / 4;
  localparam int AW        = $clog2(MAX_BYTES);
  localparam int CW        = AW + 1;

  afifo_mode_e   md;
  logic          is_play, is_stereo, is_rec, is_idle;
  logic          ack_l, ack_r, dma_w_l, dma_w_r, host_w_l, host_w_r;
  logic          l_wr, l_two, l_rd, r_wr, r_rd;
  logic [15:0]   l_wdata;
  logic [7:0]    l_rdata;
  logic [CW-1:0] cap;
  logic          l_empty, l_half, l_full, r_empty, r_half, r_full;
  logic          show_r;

  assign md        = afifo_mode_e'(mode);
  assign is_play   = (md == MODE_MONO) || (md == MODE_STEREO);
  assign is_stereo = (md == MODE_STEREO);
  assign is_rec    = (md == MODE_REC);
  assign is_idle   = (md == MODE_IDLE);

  always_comb begin
    if (size_sel[1]) cap = CW'(MAX_BYTES);
    else             cap = CW'(MIN_BYTES) << size_sel[0];
  end

  assign ack_l    = pol[POL_ACK] ? dack_l : ~dack_l;
  assign ack_r    = pol[POL_ACK] ? dack_r : ~dack_r;
  assign dma_w_l  = dma_en && dma_wr && ack_l && is_play;
  assign dma_w_r  = dma_en && dma_wr && ack_r && !ack_l && is_stereo;
  assign host_w_l = host_wr && is_play && !(is_stereo && host_ch);
  assign host_w_r = host_wr && is_stereo && host_ch;

  always_comb begin
    if (is_rec) begin
      l_wr    = codec_wr;
      l_two   = 1'b0;
      l_wdata = {8'h00, codec_wdata};
      l_rd    = host_rd || (dma_en && dma_rd && ack_l);
    end else begin
      l_wr    = dma_w_l || host_w_l;
      l_two   = wide;
      l_wdata = host_wdata;
      l_rd    = codec_rd_l && synth_go_l && is_play;
    end
  end

  assign r_wr = dma_w_r || host_w_r;
  assign r_rd = codec_rd_r && synth_go_r && is_stereo;

  afifo_chan #(.MAX_BYTES(MAX_BYTES), .AW(AW), .CW(CW)) u_left (
    .clk (clk), .rst (rst), .clr (is_idle), .cap (cap),
    .wr_en (l_wr), .wr_two (l_two), .wr_data (l_wdata),
    .rd_en (l_rd), .rd_data (l_rdata),
    .empty (l_empty), .half (l_half), .full (l_full)
  );

  afifo_chan #(.MAX_BYTES(MAX_BYTES), .AW(AW), .CW(CW)) u_right (
    .clk (clk), .rst (rst), .clr (is_idle), .cap (cap),
    .wr_en (r_wr), .wr_two (wide), .wr_data (host_wdata),
    .rd_en (r_rd), .rd_data (codec_rdata_r),
    .empty (r_empty), .half (r_half), .full (r_full)
  );

  assign host_rdata    = l_rdata;
  assign codec_rdata_l = l_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      synth_go_l <= 1'b0;
      synth_go_r <= 1'b0;
    end else begin
      synth_go_l <= is_play && (synth_go_l || l_half);
      synth_go_r <= is_stereo && (synth_go_r || r_half);
    end
  end

  assign show_r     = is_stereo && ch_sel;
  assign flag_empty = (show_r ? r_empty : l_empty) ^ pol[POL_EMPTY];
  assign flag_half  = (show_r ? r_half  : l_half)  ^ pol[POL_HALF];
  assign flag_full  = (show_r ? r_full  : l_full)  ^ pol[POL_FULL];

  assign dreq_l = (dma_en && ((is_play && !l_full) || (is_rec && !l_empty))) ^ pol[POL_REQ];
  assign dreq_r = (dma_en && is_stereo && !r_full) ^ pol[POL_REQ];

  AST_SYNTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(synth_go_l) && is_play && $past(is_play)) |-> synth_go_l); // R6
  AST_SYNTH_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(synth_go_l) |-> $past(l_half)); // R6
  AST_RIGHT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!is_stereo && $past(!is_stereo)) |-> !synth_go_r); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({l_empty, l_full})); // R2
endmodule

// File: tb/tb_stereo_audio_fifo.sv
`timescale 1ns/1ps
module tb_stereo_audio_fifo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd3, size_sel = 2'd0;
  logic wide = 1'b0, dma_en = 1'b0, ch_sel = 1'b0, host_ch = 1'b0;
  logic [4:0] pol = 5'd0;
  logic host_wr = 1'b0, host_rd = 1'b0, dma_wr = 1'b0, dma_rd = 1'b0;
  logic dack_l = 1'b1, dack_r = 1'b1;
  logic codec_rd_l = 1'b0, codec_rd_r = 1'b0, codec_wr = 1'b0;
  logic [15:0] host_wdata = 16'h0;
  logic [7:0] codec_wdata = 8'h0;
  logic [7:0] host_rdata, codec_rdata_l, codec_rdata_r;
  logic dreq_l, dreq_r, flag_empty, flag_half, flag_full, synth_go_l, synth_go_r;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  stereo_audio_fifo dut (
    .clk(clk), .rst(rst), .mode(mode), .size_sel(size_sel), .wide(wide),
    .dma_en(dma_en), .pol(pol), .ch_sel(ch_sel), .host_ch(host_ch),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata), .dma_wr(dma_wr), .dma_rd(dma_rd),
    .dack_l(dack_l), .dack_r(dack_r), .dreq_l(dreq_l), .dreq_r(dreq_r),
    .codec_rd_l(codec_rd_l), .codec_rd_r(codec_rd_r),
    .codec_rdata_l(codec_rdata_l), .codec_rdata_r(codec_rdata_r),
    .codec_wr(codec_wr), .codec_wdata(codec_wdata),
    .flag_empty(flag_empty), .flag_half(flag_half), .flag_full(flag_full),
    .synth_go_l(synth_go_l), .synth_go_r(synth_go_r)
  );

  // op[12:11]: 0 idle, 1 write, 2 codec read, 3 both; n[10:3]; flags {empty,half,full}
  localparam logic [12:0] VEC [10] = '{
    {2'd1, 8'd16, 3'b000},  // R3 16 of 32 bytes: not half
    {2'd1, 8'd1,  3'b010},  // R3 17 bytes: half
    {2'd0, 8'd1,  3'b010},  // R6 let synth_go rise
    {2'd1, 8'd15, 3'b011},  // R4 32 bytes: full
    {2'd1, 8'd3,  3'b011},  // R4 writes refused
    {2'd2, 8'd1,  3'b010},  // 31 bytes
    {2'd3, 8'd5,  3'b010},  // R11 paired ops keep 31
    {2'd2, 8'd15, 3'b000},  // R3 16 bytes
    {2'd2, 8'd16, 3'b100},  // R2 empty
    {2'd2, 8'd2,  3'b100}   // R2 reads refused
  };

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] flg();
    return {13'd0, flag_empty, flag_half, flag_full};
  endfunction

  task automatic push(input logic [15:0] d, input logic ch);
    host_wdata = d; host_ch = ch; host_wr = 1'b1;
    cyc();
    host_wr = 1'b0;
  endtask

  task automatic pop_l();
    codec_rd_l = 1'b1; cyc(); codec_rd_l = 1'b0;
  endtask

  task automatic enter(input logic [1:0] m);
    mode = 2'd3; cyc();
    mode = m; cyc();
  endtask

  task automatic dmaw();
    dma_wr = 1'b1; cyc(); dma_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (R1 run incomplete) actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    // reset state
    chk("R2 reset flags", flg(), 16'b100);
    chk("R8 reset requests", {14'd0, dreq_l, dreq_r}, 16'd0);
    chk("R6 reset synth_go", {14'd0, synth_go_l, synth_go_r}, 16'd0);

    // table walk: mono, 32 bytes, 8-bit writes
    enter(2'd0);
    for (int i = 0; i < 10; i++) begin
      for (int k = 0; k < int'(VEC[i][10:3]); k++) begin
        host_wr = VEC[i][11]; codec_rd_l = VEC[i][12];
        cyc();
        host_wr = 1'b0; codec_rd_l = 1'b0;
      end
      chk($sformatf("R2 R3 R4 R11 table step %0d", i), flg(), {13'd0, VEC[i][2:0]});
    end

    // 16-bit write with one byte free is refused
    enter(2'd0);
    for (int k = 0; k < 31; k++) push(16'h0011, 1'b0);
    wide = 1'b1; push(16'h2233, 1'b0); wide = 1'b0;
    chk("R4 wide write refused at 31 bytes", flg(), 16'b010);
    push(16'h0044, 1'b0);
    chk("R4 byte write fills to 32", flg(), 16'b011);
    for (int k = 0; k < 15; k++) pop_l();
    chk("R3 17 left after reads", flg(), 16'b010);
    pop_l();
    chk("R3 16 left after reads", flg(), 16'b000);

    // byte order
    enter(2'd0);
    wide = 1'b1;
    for (int i = 0; i < 9; i++) push({8'(8'h41 + 2*i), 8'(8'h40 + 2*i)}, 1'b0);
    cyc();
    chk("R6 synth_go_l after half", {15'd0, synth_go_l}, 16'd1);
    for (int k = 0; k < 18; k++) begin
      pop_l();
      chk($sformatf("R5 byte %0d order", k), {8'd0, codec_rdata_l}, {8'd0, 8'(8'h40 + k)});
    end
    wide = 1'b0;
    push(16'hEE77, 1'b0); push(16'hEE88, 1'b0);
    pop_l(); chk("R5 narrow low byte a", {8'd0, codec_rdata_l}, 16'h0077);
    pop_l(); chk("R5 narrow low byte b", {8'd0, codec_rdata_l}, 16'h0088);
    chk("R2 empty after drain", flg(), 16'b100);

    // capacities
    size_sel = 2'd2; enter(2'd0); wide = 1'b1;
    for (int k = 0; k < 63; k++) push(16'h1234, 1'b0);
    chk("R1 1024-bit not full at 126", flg(), 16'b010);
    push(16'h1234, 1'b0);
    chk("R1 1024-bit full at 128", flg(), 16'b011);
    size_sel = 2'd1; enter(2'd0);
    for (int k = 0; k < 31; k++) push(16'h1234, 1'b0);
    chk("R1 512-bit not full at 62", flg(), 16'b010);
    push(16'h1234, 1'b0);
    chk("R1 512-bit full at 64", flg(), 16'b011);

    // stereo routing and gating
    size_sel = 2'd0; enter(2'd1);
    for (int i = 0; i < 9; i++) push(16'h5555, 1'b1);
    ch_sel = 1'b0; #1;
    chk("R7 left flags in stereo", flg(), 16'b100);
    ch_sel = 1'b1; #1;
    chk("R7 right flags in stereo", flg(), 16'b010);
    cyc();
    chk("R6 right go, left idle", {14'd0, synth_go_l, synth_go_r}, 16'b01);

    // DMA
    dma_en = 1'b1; #1;
    chk("R8 both requests active", {14'd0, dreq_l, dreq_r}, 16'b11);
    dmaw(); ch_sel = 1'b0; #1;
    chk("R9 no ack ignores dma write", flg(), 16'b100);
    dack_l = 1'b0; dmaw(); dack_l = 1'b1;
    chk("R9 left ack writes left", flg(), 16'b000);
    dack_r = 1'b0;
    for (int k = 0; k < 7; k++) dmaw();
    dack_r = 1'b1; ch_sel = 1'b1; #1;
    chk("R9 right ack fills right", flg(), 16'b011);
    chk("R8 right request drops when full", {14'd0, dreq_l, dreq_r}, 16'b10);
    codec_rd_r = 1'b1; cyc(); codec_rd_r = 1'b0;
    chk("R8 right request back after read", {15'd0, dreq_r}, 16'd1);

    // polarity
    pol = 5'b11111; #1;
    chk("R10 inverted flags", flg(), 16'b101);
    chk("R10 inverted request", {15'd0, dreq_r}, 16'd0);
    wide = 1'b0; dack_l = 1'b0; dack_r = 1'b1; dmaw();
    chk("R10 active-high ack fills right", flg(), 16'b100);
    pol = 5'd0; dack_l = 1'b1; dack_r = 1'b1;

    // record
    enter(2'd2);
    codec_wdata = 8'h5A; codec_wr = 1'b1; cyc();
    codec_wdata = 8'h3C; cyc(); codec_wr = 1'b0;
    ch_sel = 1'b1; #1;
    chk("R7 record ignores ch_sel", flg(), 16'b000);
    chk("R8 record request", {14'd0, dreq_l, dreq_r}, 16'b10);
    host_rd = 1'b1; cyc(); host_rd = 1'b0;
    chk("R12 host read byte", {8'd0, host_rdata}, 16'h005A);
    dack_l = 1'b0; dma_rd = 1'b1; cyc(); dma_rd = 1'b0; dack_l = 1'b1;
    chk("R12 dma read byte", {8'd0, host_rdata}, 16'h003C);
    chk("R12 empty after reads", flg(), 16'b100);
    chk("R8 record request drops", {15'd0, dreq_l}, 16'd0);

    // idle clears
    enter(2'd0); ch_sel = 1'b0;
    for (int k = 0; k < 20; k++) push(16'h0099, 1'b0);
    cyc();
    chk("R6 go before idle", {15'd0, synth_go_l}, 16'd1);
    mode = 2'd3; cyc();
    chk("R13 idle empties", flg(), 16'b100);
    chk("R13 idle clears go", {14'd0, synth_go_l, synth_go_r}, 16'd0);
    mode = 2'd0; cyc();
    chk("R13 go stays low after idle", {15'd0, synth_go_l}, 16'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule